// File: doc/BRIEF.md
# Bus Fault Status and Address Capture

This unit keeps the record of bus errors seen by a small processor core. Three sticky cause flags report an instruction-side error, a precise data-side error and an imprecise data-side error. A fault-address register holds the data address of a precise error. An address-valid flag shows that this address is present.

Instruction errors arrive early, as a tag on a prefetched word. The unit keeps that tag in a one-entry issue slot. The cause is recorded only if the tagged word is actually issued. A word that is flushed leaves nothing behind.

An imprecise error can arrive while the core runs at a priority at or above the bus-fault priority. In that case the error is recorded and held pending. A numerically lower value means a more urgent priority. The pending state ends when the running priority value rises above the bus-fault value. A fault-entry request is raised whenever any recorded cause is not pending.

Software reads the flags and the address through a small register port and clears flags by writing ones.

Top module: `bus_fault_status`

## Requirements
- R1: `stat_bits` bit 0 is the instruction error, bit 1 the precise data error and bit 2 the imprecise data error. A bit reads 1 from the clock edge that records its cause. All flags, `fault_addr`, `addr_valid`, `imp_pending`, `fault_req` and `reg_rdata` are zero after reset.
- R2: A fetched word with `fetch_err` set is held in the issue slot. Its error sets bit 0 only when `issue_vld` is high while that word is in the slot. An `issue_flush` discards the slot and any word fetched in the same cycle, and wins over an issue in that cycle.
- R3: A data error with `dacc_precise` high sets bit 1. It also loads `dacc_addr` into `fault_addr` and sets `addr_valid`, provided no valid address is already held.
- R4: An imprecise data error and an instruction error set their bits and never change `fault_addr` or `addr_valid`.
- R5: An imprecise error that arrives while `cur_prio <= bf_prio` sets `imp_pending` together with bit 2. `imp_pending` stays high while that condition holds. It drops on the edge after `cur_prio > bf_prio` is seen.
- R6: A precise error that follows a pending imprecise one leaves both bits 1 and 2 set.
- R7: A register write with `reg_sel` = 0 clears each flag whose `reg_wdata` bit is 1. A flag whose `reg_wdata` bit is 0 is unchanged.
- R8: While `addr_valid` is 1, a further precise error does not overwrite `fault_addr`. Clearing bit 1 clears `addr_valid`.
- R9: When a hardware set and a write-one clear hit the same flag in one cycle, the flag stays 1. For bit 1 the new address is then captured and `addr_valid` stays 1.
- R10: `fault_req` is 1 when bit 0 or bit 1 is set, or when bit 2 is set and `imp_pending` is 0. Otherwise it is 0.
- R11: `reg_rdata` shows, one cycle after the select, the flags in bits 2:0 with zeros above when `reg_sel` = 0, and `fault_addr` when `reg_sel` = 1. Written bits above bit 2 and writes with `reg_sel` = 1 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_vld | input | 1 | A fetched word enters the issue slot |
| fetch_err | input | 1 | Bus error tag of the fetched word |
| issue_vld | input | 1 | The word in the slot is issued |
| issue_flush | input | 1 | Discard the slot contents |
| dacc_err | input | 1 | Data access bus error |
| dacc_precise | input | 1 | Data error is precise (1) or imprecise (0) |
| dacc_addr | input | AW | Data address of the failing access |
| cur_prio | input | PW | Current execution priority, lower is more urgent |
| bf_prio | input | PW | Bus-fault priority |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the flags, 1 the fault address |
| reg_wdata | input | AW | Write data, ones clear flags |
| stat_bits | output | 3 | Sticky cause flags |
| fault_addr | output | AW | Captured precise fault address |
| addr_valid | output | 1 | Fault address is held |
| imp_pending | output | 1 | Imprecise error awaiting a lower priority |
| fault_req | output | 1 | Fault-entry request |
| reg_rdata | output | AW | Registered read data |

## Verification
The hardest state to reach from the ports has three parts at once. An imprecise error must be held pending. A precise error must then arrive on top of it. A software clear must land in the same cycle as a new hardware set. Directed sequences first raise the priority so the imprecise error is held. They then inject a precise error, and later combine a precise error with a write-one clear of its own bit. A long random phase follows, with sparse errors, wandering priorities and random clear masks. A behavioural model checks that phase on every cycle.

// File: rtl/bfs_pkg.sv
package bfs_pkg;
  localparam int NCAUSE   = 3;
  localparam int IBUS_BIT = 0;
  localparam int PREC_BIT = 1;
  localparam int IMP_BIT  = 2;

  typedef logic [NCAUSE-1:0] cause_vec_t;
endpackage

// File: rtl/bfs_issue_slot.sv
module bfs_issue_slot (
  input  logic clk,
  input  logic rst,
  input  logic fetch_vld,
  input  logic fetch_err,
  input  logic issue_vld,
  input  logic issue_flush,
  output logic ibus_evt
);
  logic slot_vld_q;
  logic slot_err_q;

  assign ibus_evt = issue_vld && !issue_flush && slot_vld_q && slot_err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_vld_q <= 1'b0;
      slot_err_q <= 1'b0;
    end else if (issue_flush) begin
      slot_vld_q <= 1'b0;
      slot_err_q <= 1'b0;
    end else if (fetch_vld) begin
      slot_vld_q <= 1'b1;
      slot_err_q <= fetch_err;
    end else if (issue_vld) begin
      slot_vld_q <= 1'b0;
      slot_err_q <= 1'b0;
    end
  end

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    issue_flush |=> !slot_vld_q); // R2
endmodule

// File: rtl/bfs_addr_capture.sv
module bfs_addr_capture #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          prec_evt,
  input  logic          clr_prec,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_q,
  output logic          valid_q
);
  logic load;

  assign load = prec_evt && (!valid_q || clr_prec);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (load) addr_q <= addr_in;
      if (prec_evt)      valid_q <= 1'b1;
      else if (clr_prec) valid_q <= 1'b0;
    end
  end

  AST_ADDR_KEPT: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !clr_prec) |=> $stable(addr_q)); // R8
  AST_NO_ADDR_WITHOUT_PREC: assert property (@(posedge clk) disable iff (rst)
    !prec_evt |=> $stable(addr_q)); // R4
endmodule

// File: rtl/bfs_status_core.sv
module bfs_status_core
  import bfs_pkg::*;
#(
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ibus_evt,
  input  logic          prec_evt,
  input  logic          imp_evt,
  input  cause_vec_t    clr,
  input  logic [PW-1:0] cur_prio,
  input  logic [PW-1:0] bf_prio,
  output cause_vec_t    stat_q,
  output logic          pend_q,
  output logic          req_q
);
  cause_vec_t set_v;
  cause_vec_t stat_n;
  logic       blocked;
  logic       pend_n;

  assign blocked = (cur_prio <= bf_prio);

  always_comb begin
    set_v           = '0;
    set_v[IBUS_BIT] = ibus_evt;
    set_v[PREC_BIT] = prec_evt;
    set_v[IMP_BIT]  = imp_evt;
  end

  genvar g;
  generate
    for (g = 0; g < NCAUSE; g++) begin : g_flag
      assign stat_n[g] = set_v[g] | (stat_q[g] & ~clr[g]);
    end
  endgenerate

  assign pend_n = stat_n[IMP_BIT] && blocked && (pend_q || imp_evt);

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      pend_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      stat_q <= stat_n;
      pend_q <= pend_n;
      req_q  <= stat_n[IBUS_BIT] | stat_n[PREC_BIT] | (stat_n[IMP_BIT] & ~pend_n);
    end
  end

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    prec_evt |=> stat_q[PREC_BIT]); // R9
  AST_PEND_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    pend_q |-> stat_q[IMP_BIT]); // R5
  AST_REQ_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    req_q |-> (stat_q != '0)); // R10
  AST_NO_SPURIOUS_IBUS: assert property (@(posedge clk) disable iff (rst)
    (!stat_q[IBUS_BIT] && !ibus_evt) |=> !stat_q[IBUS_BIT]); // R2
endmodule

// File: rtl/bus_fault_status.sv
module bus_fault_status
  import bfs_pkg::*;
#(
  parameter int AW = 32,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fetch_vld,
  input  logic          fetch_err,
  input  logic          issue_vld,
  input  logic          issue_flush,
  input  logic          dacc_err,
  input  logic          dacc_precise,
  input  logic [AW-1:0] dacc_addr,
  input  logic [PW-1:0] cur_prio,
  input  logic [PW-1:0] bf_prio,
  input  logic          reg_wr,
  input  logic          reg_sel,
  input  logic [AW-1:0] reg_wdata,
  output logic [2:0]    stat_bits,
  output logic [AW-1:0] fault_addr,
  output logic          addr_valid,
  output logic          imp_pending,
  output logic          fault_req,
  output logic [AW-1:0] reg_rdata
);
  localparam int PADW = AW - NCAUSE;

  logic       ibus_evt;
  logic       prec_evt;
  logic       imp_evt;
  cause_vec_t clr;
  cause_vec_t stat_q;

  assign prec_evt = dacc_err && dacc_precise;
  assign imp_evt  = dacc_err && !dacc_precise;
  assign clr      = (reg_wr && !reg_sel) ? reg_wdata[NCAUSE-1:0] : '0;

  bfs_issue_slot u_slot (
    .clk(clk), .rst(rst),
    .fetch_vld(fetch_vld), .fetch_err(fetch_err),
    .issue_vld(issue_vld), .issue_flush(issue_flush),
    .ibus_evt(ibus_evt)
  );

  bfs_status_core #(.PW(PW)) u_core (
    .clk(clk), .rst(rst),
    .ibus_evt(ibus_evt), .prec_evt(prec_evt), .imp_evt(imp_evt),
    .clr(clr), .cur_prio(cur_prio), .bf_prio(bf_prio),
    .stat_q(stat_q), .pend_q(imp_pending), .req_q(fault_req)
  );

  bfs_addr_capture #(.AW(AW)) u_addr (
    .clk(clk), .rst(rst),
    .prec_evt(prec_evt), .clr_prec(clr[PREC_BIT]),
    .addr_in(dacc_addr), .addr_q(fault_addr), .valid_q(addr_valid)
  );

  assign stat_bits = stat_q;

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_sel) reg_rdata <= fault_addr;
    else reg_rdata <= {{PADW{1'b0}}, stat_q};
  end

  AST_VALID_FOLLOWS_FLAG: assert property (@(posedge clk) disable iff (rst)
    addr_valid |-> stat_bits[PREC_BIT]); // R8
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(!reg_sel) |-> (reg_rdata[AW-1:NCAUSE] == '0)); // R11
endmodule

// File: tb/test_bus_fault_status.sv
module test_bus_fault_status;
  localparam int AW = 32;
  localparam int PW = 3;

  logic clk = 0, rst = 1;
  logic fetch_vld = 0, fetch_err = 0, issue_vld = 0, issue_flush = 0;
  logic dacc_err = 0, dacc_precise = 0;
  logic [AW-1:0] dacc_addr = '0;
  logic [PW-1:0] cur_prio = 7, bf_prio = 2;
  logic reg_wr = 0, reg_sel = 0;
  logic [AW-1:0] reg_wdata = '0;
  logic [2:0] stat_bits;
  logic [AW-1:0] fault_addr, reg_rdata;
  logic addr_valid, imp_pending, fault_req;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bus_fault_status #(.AW(AW), .PW(PW)) i_bus_fault_status (.*);

  // behavioural reference model
  bit m_sv, m_se, m_ib, m_pr, m_im, m_pend, m_req, m_val;
  logic [AW-1:0] m_addr, m_rd;

  always @(posedge clk) begin
    if (rst) begin
      {m_sv, m_se, m_ib, m_pr, m_im, m_pend, m_req, m_val} = '0;
      m_addr = '0; m_rd = '0;
    end else begin
      bit ie, pe, xe, c0, c1, c2, blk;
      m_rd = reg_sel ? m_addr : AW'({m_im, m_pr, m_ib});
      ie = issue_vld && !issue_flush && m_sv && m_se;
      if (issue_flush) begin m_sv = 0; m_se = 0; end
      else if (fetch_vld) begin m_sv = 1; m_se = fetch_err; end
      else if (issue_vld) begin m_sv = 0; m_se = 0; end
      pe = dacc_err && dacc_precise;
      xe = dacc_err && !dacc_precise;
      c0 = reg_wr && !reg_sel && reg_wdata[0];
      c1 = reg_wr && !reg_sel && reg_wdata[1];
      c2 = reg_wr && !reg_sel && reg_wdata[2];
      blk = cur_prio <= bf_prio;
      if (pe && (!m_val || c1)) m_addr = dacc_addr;
      if (pe) m_val = 1; else if (c1) m_val = 0;
      m_ib = ie || (m_ib && !c0);
      m_pr = pe || (m_pr && !c1);
      m_im = xe || (m_im && !c2);
      m_pend = m_im && blk && (m_pend || xe);
      m_req = m_ib || m_pr || (m_im && !m_pend);
    end
  end

  task automatic check(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!rst && !done) begin
    check("R1 model stat", AW'(stat_bits), AW'({m_im, m_pr, m_ib}));
    check("R3 model addr", fault_addr, m_addr);
    check("R8 model valid", AW'(addr_valid), AW'(m_val));
    check("R5 model pend", AW'(imp_pending), AW'(m_pend));
    check("R10 model req", AW'(fault_req), AW'(m_req));
    check("R11 model rdata", reg_rdata, m_rd);
  end

  task automatic cyc(); @(negedge clk); endtask
  task automatic idle();
    fetch_vld = 0; fetch_err = 0; issue_vld = 0; issue_flush = 0;
    dacc_err = 0; dacc_precise = 0; reg_wr = 0; reg_wdata = '0;
  endtask
  task automatic wclr(logic [AW-1:0] m);
    reg_sel = 0; reg_wr = 1; reg_wdata = m; cyc(); idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst = 0; cyc();
    check("R1 reset stat", AW'(stat_bits), 0);
    check("R1 reset req", AW'(fault_req), 0);
    check("R1 reset valid", AW'(addr_valid), 0);
    // R2 flushed word
    fetch_vld = 1; fetch_err = 1; cyc(); idle();
    issue_flush = 1; cyc(); idle();
    issue_vld = 1; cyc(); idle(); cyc();
    check("R2 flush no trace", AW'(stat_bits), 0);
    // R2 issued word
    fetch_vld = 1; fetch_err = 1; cyc(); idle();
    cyc();
    check("R2 not yet issued", AW'(stat_bits), 0);
    issue_vld = 1; cyc(); idle();
    check("R2 issued sets bit0", AW'(stat_bits), 3'b001);
    check("R4 ibus no addr", AW'(addr_valid), 0);
    check("R10 req on ibus", AW'(fault_req), 1);
    wclr(32'h6); cyc();
    check("R7 zero writes keep", AW'(stat_bits), 3'b001);
    wclr(32'h1); cyc();
    check("R7 w1c clears", AW'(stat_bits), 0);
    check("R10 req drops", AW'(fault_req), 0);
    // R5 pending imprecise
    cur_prio = 1; bf_prio = 2;
    dacc_err = 1; dacc_precise = 0; dacc_addr = 32'hDEAD; cyc(); idle();
    check("R5 imp set", AW'(stat_bits), 3'b100);
    check("R5 pending", AW'(imp_pending), 1);
    check("R4 imp no addr", AW'(addr_valid), 0);
    check("R10 no req while pending", AW'(fault_req), 0);
    cyc(); cyc();
    check("R5 still pending", AW'(imp_pending), 1);
    dacc_err = 1; dacc_precise = 1; dacc_addr = 32'h1000; cyc(); idle();
    check("R6 both bits", AW'(stat_bits), 3'b110);
    check("R3 addr captured", fault_addr, 32'h1000);
    check("R3 valid", AW'(addr_valid), 1);
    cur_prio = 5; cyc();
    check("R5 released", AW'(imp_pending), 0);
    dacc_err = 1; dacc_precise = 1; dacc_addr = 32'h2000; cyc(); idle();
    check("R8 addr kept", fault_addr, 32'h1000);
    // R11 reserved bits, address select read
    wclr(32'hFFFF_FFF8); cyc();
    check("R11 reserved ignored", reg_rdata, 32'h6);
    reg_sel = 1; reg_wr = 1; reg_wdata = 32'hFFFF_FFFF; cyc(); idle(); cyc();
    check("R11 addr read", reg_rdata, 32'h1000);
    check("R11 sel1 write ignored", AW'(stat_bits), 3'b110);
    reg_sel = 0;
    // R9 set vs clear
    dacc_err = 1; dacc_precise = 1; dacc_addr = 32'h3000;
    reg_wr = 1; reg_wdata = 32'h2; cyc(); idle();
    check("R9 set wins", AW'(stat_bits[1]), 1);
    check("R9 new addr", fault_addr, 32'h3000);
    wclr(32'h2);
    check("R8 valid cleared", AW'(addr_valid), 0);
    wclr(32'h4);
    check("R7 all clear", AW'(stat_bits), 0);
    // random phase, compared on every cycle by the model
    for (int i = 0; i < 4000; i++) begin
      fetch_vld = ($urandom % 3) == 0; fetch_err = $urandom % 2;
      issue_vld = ($urandom % 3) == 0; issue_flush = ($urandom % 7) == 0;
      dacc_err = ($urandom % 9) == 0; dacc_precise = $urandom % 2;
      dacc_addr = $urandom;
      if ($urandom % 10 == 0) cur_prio = PW'($urandom);
      if ($urandom % 25 == 0) bf_prio = PW'($urandom);
      reg_wr = ($urandom % 6) == 0; reg_sel = ($urandom % 4) == 0;
      reg_wdata = $urandom;
      cyc();
    end
    idle(); cyc();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule